// File: doc/BRIEF.md
# Poison-tagged speculative load datapath

This block is a small execution datapath built around a general register file. Each 64-bit register carries one extra poison bit. The bit records a fault that was put off instead of being raised. The block takes one instruction per cycle on its instruction port and executes it in that same cycle. It drives a memory port whose read data and fault flag come back combinationally. It reports a fault, or a redirect to recovery code, on registered outputs in the cycle after the instruction.

A speculative load never raises a fault. If the access would fault, or if its address is already poisoned, the load poisons its destination register. Arithmetic carries the poison forward to every result that depends on it. An explicit check instruction tests a single register. When that register is poisoned, the check emits a redirect carrying the recovery target taken from the instruction. Ordinary loads raise their faults at once.

Registers can only be observed through the normal interface:
- A speculative load into r0 shows a register's value on `mem_addr` without changing any state.
- A check shows its poison bit.

Top module: `psn_spec_core`

## Requirements
- R1: After reset, every register holds zero with its poison bit clear, predicates p1 to p7 are false, and `fault_valid` and `redirect_valid` are low.
- R2: A speculative load (op 2) whose access reports `mem_fault` poisons its destination and raises no fault.
- R3: A speculative load whose address register is poisoned issues no memory request, poisons its destination and raises no fault.
- R4: The results of add, shift-and-add and OR-immediate are poisoned whenever any source they read is poisoned.
- R5: A check (op 7) on a poisoned register sets `redirect_valid` in the next cycle, with `redirect_target` equal to the instruction's imm field. On a clean register there is no redirect.
- R6: A normal load (op 1) that gets `mem_fault` sets `fault_valid` with `fault_code` 1 in the next cycle and leaves its destination unchanged.
- R7: A normal load whose address register is poisoned issues no request, sets `fault_valid` with `fault_code` 2 and leaves its destination unchanged.
- R8: An unsigned compare (op 5) writes (rs1 > rs2) to predicate p[rd[2:0]] and the complement to p[aux]. If either source is poisoned, both predicates are cleared.
- R9: An instruction is ignored when its qualifying predicate p[qp] is false, or when `instr_valid` is low. It then makes no register or predicate write, no request, no fault and no redirect, including for a check on a poisoned register.
- R10: Add (op 3) gives rs1 + rs2 mod 2^64. Shift-and-add (op 4) gives (rs1 << aux) + rs2, with aux taking values 0 to 7.
- R11: A successful normal load, or any unpoisoned result, clears the destination's poison bit. OR-immediate (op 6) gives rs1 | imm. r0 always reads as zero and clean, whatever is written to it.
- R12: Predicate p0 always reads true, and compares that target it have no effect on it.
- R13: The instruction word layout is op [3:0], qp [6:4], rd [10:7], rs1 [14:11], rs2 [18:15], aux [21:19], imm [31:23]. Opcode 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| mem_req | output | 1 | Load request this cycle |
| mem_addr | output | 16 | Load address (low bits of rs1) |
| mem_rdata | input | 64 | Read data, same cycle |
| mem_fault | input | 1 | Access would fault, same cycle |
| fault_valid | output | 1 | Fault raised by the previous instruction |
| fault_code | output | 2 | 1 memory fault, 2 poison consumed |
| redirect_valid | output | 1 | Check failed on the previous instruction |
| redirect_target | output | 9 | Recovery target |

## Verification
Some properties are watched on every cycle by the assertions:
- a speculative load never raises a fault;
- a check redirects exactly when its source is poisoned, and carries the right target;
- normal loads report the right fault code;
- a predicated-off instruction leaves both outputs quiet;
- compares produce complementary predicates;
- every register write lands with its poison bit.

Other behaviour can only be shown by the bench's instruction sequences, which observe poison spreading through chains of arithmetic, register values after faulting loads, the shift-and-add results, p0 refusing writes, and state cleared by reset.

// File: rtl/psn_spec_pkg.sv
package psn_spec_pkg;
  localparam int XLEN  = 64;
  localparam int NREG  = 16;
  localparam int RIDX  = $clog2(NREG);
  localparam int NPRED = 8;
  localparam int PIDX  = $clog2(NPRED);
  localparam int CNTW  = 3;
  localparam int IMMW  = 9;
  localparam int IW    = 32;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_LD = 4'd1, OP_LDSPEC = 4'd2, OP_ADD = 4'd3,
    OP_SHLADD = 4'd4, OP_CMPGT = 4'd5, OP_ORI = 4'd6, OP_CHKP = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_MEM = 2'd1, FLT_POISON = 2'd2
  } flt_e;

  typedef struct packed {
    logic [IMMW-1:0] imm;
    logic            rsv;
    logic [CNTW-1:0] aux;
    logic [RIDX-1:0] rs2;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rd;
    logic [PIDX-1:0] qp;
    op_e             op;
  } instr_t;

  function automatic logic [XLEN-1:0] shl_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic [CNTW-1:0] cnt);
    return (a << cnt) + b;
  endfunction

  function automatic logic poison_join(input logic pa, input logic pb);
    return pa | pb;
  endfunction

  function automatic logic gt_u(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a > b;
  endfunction
endpackage

// File: rtl/psn_regfile.sv
module psn_regfile #(
  parameter int W = 64,
  parameter int N = 16,
  localparam int IX = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IX-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  output logic          ra_psn,
  input  logic [IX-1:0] rb_idx,
  output logic [W-1:0]  rb_data,
  output logic          rb_psn,
  input  logic          we,
  input  logic [IX-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          wpsn
);
  logic [W-1:0] data_q [N];
  logic         psn_q  [N];

  assign data_q[0] = '0;
  assign psn_q[0]  = 1'b0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[g] <= '0;
        psn_q[g]  <= 1'b0;
      end else if (we && wa == IX'(g)) begin
        data_q[g] <= wd;
        psn_q[g]  <= wpsn;
      end
    end
  end

  assign ra_data = data_q[ra_idx];
  assign ra_psn  = psn_q[ra_idx];
  assign rb_data = data_q[rb_idx];
  assign rb_psn  = psn_q[rb_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we && wa != '0 |=> data_q[$past(wa)] == $past(wd) && psn_q[$past(wa)] == $past(wpsn)); // R11
endmodule

// File: rtl/psn_predfile.sv
module psn_predfile #(
  parameter int N = 8,
  localparam int IX = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IX-1:0] rd_idx,
  output logic          rd_val,
  input  logic          we,
  input  logic [IX-1:0] pt_idx,
  input  logic          pt_val,
  input  logic [IX-1:0] pf_idx,
  input  logic          pf_val
);
  logic pq [N];

  assign pq[0] = 1'b1;

  for (genvar g = 1; g < N; g++) begin : g_pred
    always_ff @(posedge clk) begin
      if (!rst_n)                        pq[g] <= 1'b0;
      else if (we && pt_idx == IX'(g))   pq[g] <= pt_val;
      else if (we && pf_idx == IX'(g))   pq[g] <= pf_val;
    end
  end

  assign rd_val = pq[rd_idx];

  AST_PRED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    we && pt_idx != pf_idx && pt_idx != '0 && pf_idx != '0 && (pt_val || pf_val)
    |=> pq[$past(pt_idx)] != pq[$past(pf_idx)]); // R8
endmodule

// File: rtl/psn_spec_core.sv
module psn_spec_core
  import psn_spec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [IW-1:0]     instr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_fault,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              redirect_valid,
  output logic [IMMW-1:0]   redirect_target
);
  instr_t ins;
  assign ins = instr_t'(instr);

  logic            qp_true, go;
  logic [XLEN-1:0] rs1_data, rs2_data, wr_data;
  logic            rs1_psn, rs2_psn, wr_en, wr_psn;
  logic            pred_we, pt_val, pf_val;
  logic            nxt_fault, nxt_redir;
  flt_e            nxt_code;

  // named events for the assertions
  logic exec_ld, exec_lds, exec_chk;

  psn_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ins.rs1), .ra_data(rs1_data), .ra_psn(rs1_psn),
    .rb_idx(ins.rs2), .rb_data(rs2_data), .rb_psn(rs2_psn),
    .we(wr_en), .wa(ins.rd), .wd(wr_data), .wpsn(wr_psn)
  );

  psn_predfile #(.N(NPRED)) u_pf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ins.qp), .rd_val(qp_true),
    .we(pred_we), .pt_idx(ins.rd[PIDX-1:0]), .pt_val(pt_val),
    .pf_idx(ins.aux), .pf_val(pf_val)
  );

  assign go       = instr_valid && qp_true;
  assign exec_ld  = go && ins.op == OP_LD;
  assign exec_lds = go && ins.op == OP_LDSPEC;
  assign exec_chk = go && ins.op == OP_CHKP;

  assign mem_addr = rs1_data[ADDR_W-1:0];
  assign mem_req  = (exec_ld || exec_lds) && !rs1_psn;

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = '0;
    wr_psn    = 1'b0;
    pred_we   = 1'b0;
    pt_val    = 1'b0;
    pf_val    = 1'b0;
    nxt_fault = 1'b0;
    nxt_code  = FLT_NONE;
    nxt_redir = 1'b0;
    if (go) begin
      case (ins.op)
        OP_LD: begin
          if (rs1_psn) begin
            nxt_fault = 1'b1;
            nxt_code  = FLT_POISON;
          end else if (mem_fault) begin
            nxt_fault = 1'b1;
            nxt_code  = FLT_MEM;
          end else begin
            wr_en   = 1'b1;
            wr_data = mem_rdata;
          end
        end
        OP_LDSPEC: begin
          wr_en = 1'b1;
          if (rs1_psn || mem_fault) wr_psn  = 1'b1;
          else                      wr_data = mem_rdata;
        end
        OP_ADD: begin
          wr_en   = 1'b1;
          wr_data = rs1_data + rs2_data;
          wr_psn  = poison_join(rs1_psn, rs2_psn);
        end
        OP_SHLADD: begin
          wr_en   = 1'b1;
          wr_data = shl_add(rs1_data, rs2_data, ins.aux);
          wr_psn  = poison_join(rs1_psn, rs2_psn);
        end
        OP_ORI: begin
          wr_en   = 1'b1;
          wr_data = rs1_data | XLEN'(ins.imm);
          wr_psn  = rs1_psn;
        end
        OP_CMPGT: begin
          pred_we = 1'b1;
          if (!poison_join(rs1_psn, rs2_psn)) begin
            pt_val = gt_u(rs1_data, rs2_data);
            pf_val = !pt_val;
          end
        end
        OP_CHKP: nxt_redir = rs1_psn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_valid     <= 1'b0;
      fault_code      <= FLT_NONE;
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
    end else begin
      fault_valid     <= nxt_fault;
      fault_code      <= nxt_code;
      redirect_valid  <= nxt_redir;
      redirect_target <= nxt_redir ? ins.imm : '0;
    end
  end

  AST_SPEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exec_lds |=> !fault_valid); // R2
  AST_CHK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    exec_chk && rs1_psn |=> redirect_valid && redirect_target == $past(instr[IW-1:IW-IMMW])); // R5
  AST_CHK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    exec_chk && !rs1_psn |=> !redirect_valid); // R5
  AST_LD_MEMFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ld && !rs1_psn && mem_fault |=> fault_valid && fault_code == FLT_MEM); // R6
  AST_LD_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ld && rs1_psn |=> fault_valid && fault_code == FLT_POISON); // R7
  AST_QP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !fault_valid && !redirect_valid); // R9
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_valid && redirect_valid)); // R5
endmodule

// File: tb/sim_psn_spec_core.sv
module sim_psn_spec_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        mem_fault;
  logic        fault_valid;
  logic [1:0]  fault_code;
  logic        redirect_valid;
  logic [8:0]  redirect_target;
  logic [15:0] flt_a = 16'hFFFF;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psn_spec_core u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
    .fault_valid(fault_valid), .fault_code(fault_code),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target)
  );

  // memory model: word at address a holds a + 0x100; address 0 and flt_a fault
  always_comb begin
    mem_rdata = 64'(mem_addr) + 64'h100;
    mem_fault = mem_req && (mem_addr == 16'h0 || mem_addr == flt_a);
  end

  function automatic logic [31:0] enc(int op, int qp, int rd, int rs1, int rs2, int aux, int imm);
    return {imm[8:0], 1'b0, aux[2:0], rs2[3:0], rs1[3:0], rd[3:0], qp[2:0], op[3:0]};
  endfunction

  // row: tag, instr, req, addr, fault, code, redirect, target
  function automatic logic [65:0] row(int tag, logic [31:0] i, int rq, int ad, int fl, int cd, int rr, int tg);
    return {tag[3:0], i, rq[0], ad[15:0], fl[0], cd[1:0], rr[0], tg[8:0]};
  endfunction

  localparam int NV = 54;
  localparam logic [65:0] TAB [NV] = '{
    row(11, enc(6,0,1,0,0,0,5),    0,0,0,0,0,0),       // R11 r1 = 5
    row(11, enc(2,0,0,1,0,0,0),    1,5,0,0,0,0),       // R11 peek r1
    row(11, enc(6,0,2,0,0,0,3),    0,0,0,0,0,0),       // R11 r2 = 3
    row(10, enc(4,0,3,1,2,2,0),    0,0,0,0,0,0),       // R10 r3 = 5*4+3
    row(10, enc(2,0,0,3,0,0,0),    1,23,0,0,0,0),      // R10 peek r3
    row(10, enc(3,0,4,3,1,0,0),    0,0,0,0,0,0),       // R10 r4 = 23+5
    row(10, enc(2,0,0,4,0,0,0),    1,28,0,0,0,0),      // R10 peek r4
    row(10, enc(4,0,15,1,0,7,0),   0,0,0,0,0,0),       // R10 r15 = 5<<7
    row(10, enc(2,0,0,15,0,0,0),   1,640,0,0,0,0),     // R10 peek r15
    row(11, enc(1,0,5,1,0,0,0),    1,5,0,0,0,0),       // R11 ld r5
    row(11, enc(2,0,0,5,0,0,0),    1,261,0,0,0,0),     // R11 peek r5 = 0x105
    row(2,  enc(2,0,6,0,0,0,0),    1,0,0,0,0,0),       // R2 spec ld faulting
    row(2,  enc(7,0,0,6,0,0,85),   0,0,0,0,1,85),      // R2 r6 poisoned
    row(4,  enc(3,0,7,6,1,0,0),    0,0,0,0,0,0),       // R4 add poisons r7
    row(4,  enc(7,0,0,7,0,0,102),  0,0,0,0,1,102),     // R4
    row(4,  enc(4,0,8,1,7,1,0),    0,0,0,0,0,0),       // R4 shladd rs2 poisoned
    row(4,  enc(7,0,0,8,0,0,119),  0,0,0,0,1,119),     // R4
    row(4,  enc(6,0,9,7,0,0,1),    0,0,0,0,0,0),       // R4 ori poisoned
    row(4,  enc(7,0,0,9,0,0,17),   0,0,0,0,1,17),      // R4
    row(3,  enc(2,0,10,7,0,0,0),   0,0,0,0,0,0),       // R3 spec ld poisoned addr
    row(3,  enc(7,0,0,10,0,0,18),  0,0,0,0,1,18),      // R3
    row(5,  enc(7,0,0,1,0,0,19),   0,0,0,0,0,0),       // R5 clean check
    row(7,  enc(1,0,11,7,0,0,0),   0,0,1,2,0,0),       // R7 ld poisoned addr
    row(7,  enc(7,0,0,11,0,0,20),  0,0,0,0,0,0),       // R7 r11 untouched
    row(6,  enc(6,0,12,0,0,0,9),   0,0,0,0,0,0),       // R6 r12 = 9
    row(6,  enc(1,0,12,0,0,0,0),   1,0,1,1,0,0),       // R6 ld faulting
    row(6,  enc(2,0,0,12,0,0,0),   1,9,0,0,0,0),       // R6 r12 unchanged
    row(11, enc(1,0,6,1,0,0,0),    1,5,0,0,0,0),       // R11 ld clears r6
    row(11, enc(7,0,0,6,0,0,21),   0,0,0,0,0,0),       // R11
    row(8,  enc(5,0,1,1,2,2,0),    0,0,0,0,0,0),       // R8 p1=1 p2=0
    row(9,  enc(6,2,13,0,0,0,7),   0,0,0,0,0,0),       // R9 off
    row(8,  enc(6,1,14,0,0,0,8),   0,0,0,0,0,0),       // R8 on
    row(9,  enc(2,0,0,13,0,0,0),   1,0,0,0,0,0),       // R9 r13 still 0
    row(8,  enc(2,0,0,14,0,0,0),   1,8,0,0,0,0),       // R8 r14 = 8
    row(9,  enc(7,2,0,7,0,0,33),   0,0,0,0,0,0),       // R9 check off
    row(8,  enc(7,1,0,7,0,0,34),   0,0,0,0,1,34),      // R8
    row(9,  enc(1,2,13,0,0,0,0),   0,0,0,0,0,0),       // R9 ld off
    row(8,  enc(5,0,1,2,1,2,0),    0,0,0,0,0,0),       // R8 p1=0 p2=1
    row(8,  enc(7,2,0,7,0,0,35),   0,0,0,0,1,35),      // R8
    row(8,  enc(7,1,0,7,0,0,36),   0,0,0,0,0,0),       // R8
    row(8,  enc(5,0,3,1,2,4,0),    0,0,0,0,0,0),       // R8 p3=1 p4=0
    row(8,  enc(7,3,0,7,0,0,37),   0,0,0,0,1,37),      // R8
    row(8,  enc(5,0,3,7,1,4,0),    0,0,0,0,0,0),       // R8 poisoned compare
    row(8,  enc(7,3,0,7,0,0,38),   0,0,0,0,0,0),       // R8 p3 cleared
    row(8,  enc(7,4,0,7,0,0,39),   0,0,0,0,0,0),       // R8 p4 cleared
    row(12, enc(5,0,0,2,1,5,0),    0,0,0,0,0,0),       // R12 write p0 false
    row(12, enc(7,0,0,7,0,0,40),   0,0,0,0,1,40),      // R12 p0 still true
    row(8,  enc(7,5,0,7,0,0,41),   0,0,0,0,1,41),      // R8 p5 complement
    row(11, enc(3,0,0,7,7,0,0),    0,0,0,0,0,0),       // R11 write r0
    row(11, enc(2,0,0,0,0,0,0),    1,0,0,0,0,0),       // R11 r0 clean zero
    row(8,  enc(5,0,6,1,1,7,0),    0,0,0,0,0,0),       // R8 equal: p6=0 p7=1
    row(8,  enc(7,6,0,7,0,0,42),   0,0,0,0,0,0),       // R8
    row(8,  enc(7,7,0,7,0,0,43),   0,0,0,0,1,43),      // R8
    row(13, enc(0,0,0,7,0,0,44),   0,0,0,0,0,0)        // R13 opcode 0 no-op
  };

  task automatic check(int tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(int tag, logic [31:0] i, int rq, int ad, int fl, int cd, int rr, int tg,
                      bit vld = 1'b1);
    @(negedge clk);
    instr_valid = vld;
    instr = i;
    #1;
    check(tag, "mem_req", longint'(mem_req), longint'(rq));
    if (rq != 0) check(tag, "mem_addr", longint'(mem_addr), longint'(ad));
    @(posedge clk);
    #1;
    check(tag, "fault_valid", longint'(fault_valid), longint'(fl));
    check(tag, "fault_code", longint'(fault_code), longint'(cd));
    check(tag, "redirect_valid", longint'(redirect_valid), longint'(rr));
    check(tag, "redirect_target", longint'(redirect_target), longint'(tg));
    instr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, "reset fault_valid", longint'(fault_valid), 0);   // R1
    check(1, "reset redirect_valid", longint'(redirect_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, enc(2,0,0,3,0,0,0), 1,0,0,0,0,0);                  // R1 r3 zero
    step(1, enc(7,0,0,3,0,0,1), 0,0,0,0,0,0);                  // R1 r3 clean

    for (int k = 0; k < NV; k++) begin
      logic [65:0] v;
      v = TAB[k];
      step(int'(v[65:62]), v[61:30], int'(v[29]), int'(v[28:13]), int'(v[12]),
           int'(v[11:10]), int'(v[9]), int'(v[8:0]));
    end

    // R9: instr_valid low, even for a check on a poisoned register
    step(9, enc(7,0,0,7,0,0,50), 0,0,0,0,0,0, 1'b0);
    step(9, enc(1,0,14,7,0,0,0), 0,0,0,0,0,0, 1'b0);
    // programmable fault address at 5
    flt_a = 16'd5;
    step(6, enc(1,0,14,1,0,0,0), 1,5,1,1,0,0);                 // R6
    step(2, enc(2,0,15,1,0,0,0), 1,5,0,0,0,0);                 // R2
    step(2, enc(7,0,0,15,0,0,51), 0,0,0,0,1,51);               // R2
    step(6, enc(2,0,0,14,0,0,0), 1,8,0,0,0,0);                 // R6 r14 kept 8
    flt_a = 16'hFFFF;
    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check(1, "reset fault_valid", longint'(fault_valid), 0);   // R1
    @(negedge clk);
    rst_n = 1'b1;
    step(1, enc(2,0,0,1,0,0,0), 1,0,0,0,0,0);                  // R1 r1 zero
    step(1, enc(7,0,0,7,0,0,52), 0,0,0,0,0,0);                 // R1 poison cleared
    step(1, enc(6,5,2,0,0,0,1), 0,0,0,0,0,0);                  // R1 p5 false
    step(1, enc(2,0,0,2,0,0,0), 1,0,0,0,0,0);                  // R1 r2 still 0
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule